// File: doc/BRIEF.md
# Double-Buffered Display Plane Register Bank

This block holds the configuration of one display plane as a bank of twelve 32-bit registers. Each register has two copies. Software fills the pending copy through a simple single-cycle write port. The active copy drives the plane hardware. A pending value reaches the active copy only when two things are true: the register is armed, and the frame-boundary strobe `frame_tick` is high. All armed registers move together in that one cycle, and their arm flags then clear. This lets software build a complete new plane state across many writes and have it take effect at one frame edge, with no torn configuration.

Each register has its own arming rule:

- **Surface group.** These registers are armed by a write to the surface-address register. The group is surface, stride, position, size and scale.
- **Self-arming.** These registers arm on their own write. They are the four offset registers and the two colour-conversion registers.
- **Control register.** It arms on its own write only while the active plane-enable bit is clear. While the plane is enabled, it waits for a surface write.

So the usual update order is: write the surface-group registers, then control, then surface last.

The bank also keeps a status flag. A small state machine in `plane_arm_fsm` tracks whether any arm flag is set. It has two states:

| State | Meaning |
|---|---|
| `ST_QUIET` | No register is armed. |
| `ST_ARMED` | At least one register is armed. |

Its transitions are:

| Transition | Condition |
|---|---|
| `ST_QUIET` to `ST_ARMED` | Any arm event. |
| `ST_ARMED` to `ST_QUIET` | `frame_tick` with no new arm event in the same cycle. |
| `ST_ARMED` to `ST_ARMED` | Otherwise. |

Top module: `plane_shadow_regs`

## Requirements
- R1: After reset, every pending and active copy is zero. `plane_on` is 0 and `arm_busy` is 0.
- R2: The register map is: 0 control, 1 surface, 2 stride, 3 position, 4 size, 5 scale, 6 tile offset, 7 linear offset, 8 combined offset, 9 auxiliary offset, 10 colour conversion A, 11 colour conversion B.
  - A write lands in the pending copy, and `rd_data` returns it from the next cycle.
  - Active register k appears on `act_flat[32k+31:32k]`.
- R3: A write to surface (address 1) arms surface, stride, position, size and scale. The next `frame_tick` copies their pending values to active.
- R4: A surface-group register written without a later surface write is not copied by `frame_tick`. Its active value is unchanged.
- R5: `plane_on` is bit 31 of the active control register. A control write while `plane_on` is 0 self-arms, so the next `frame_tick` makes it active.
- R6: A control write while `plane_on` is 1 is not copied by `frame_tick` until a surface write has armed it.
- R7: The tile, linear, combined and auxiliary offset registers (addresses 6 to 9) arm on their own write, with no surface write needed.
- R8: The colour conversion registers (addresses 10 and 11) arm on their own write.
- R9: Rewriting a register that is already armed replaces its pending value and keeps it armed. `frame_tick` then copies the latest value.
- R10: `arm_busy` is 1 exactly while any arm flag is set. After a `frame_tick` with no new arming write, it is 0.
- R11: Writes to addresses 12 to 15 are ignored. They arm nothing, and reads of those addresses return 0.
- R12: On an enabled plane, the disable sequence is: write control 0, write scale 0, then write surface. After the next `frame_tick`, `plane_on` is 0 and the active scale is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write register index |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read register index |
| rd_data | output | 32 | Pending value of the addressed register |
| frame_tick | input | 1 | Frame-boundary strobe |
| act_flat | output | 384 | All active copies, register k at bits 32k+31:32k |
| plane_on | output | 1 | Bit 31 of the active control register |
| arm_busy | output | 1 | High while any register is armed |

## Verification
The bench builds the block with its default values: 32-bit data, a 4-bit address and the enable flag at bit 31. With a 4-bit address, four unmapped indices exist, so the ignored-write case can be exercised. Bit 31 lets control values with and without the enable bit show both behaviours of the control register. The directed sequences cover the cases where the arm rules differ:
- a strobe with only the surface group written;
- a control write while enabled versus while disabled;
- a rewrite after the surface write but before the strobe;
- the full disable sequence.

// File: rtl/plane_regs_pkg.sv
package plane_regs_pkg;
    localparam int PR_NUM_REGS = 12;

    localparam int IDX_CTRL  = 0;
    localparam int IDX_SURF  = 1;

    typedef enum logic [1:0] {
        ARM_BY_SURF     = 2'd0,
        ARM_SELF        = 2'd1,
        ARM_SELF_IF_OFF = 2'd2
    } arm_rule_e;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_e;

    function automatic arm_rule_e rule_of(input int idx);
        if (idx == IDX_CTRL)
            return ARM_SELF_IF_OFF;
        else if (idx >= 6)
            return ARM_SELF;
        else
            return ARM_BY_SURF;
    endfunction
endpackage

// File: rtl/plane_reg_slot.sv
module plane_reg_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              arm_set,
    input  logic              commit,
    output logic [DATA_W-1:0] pend,
    output logic [DATA_W-1:0] act,
    output logic              armed
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= '0;
            act   <= '0;
            armed <= 1'b0;
        end else begin
            if (wr_hit)
                pend <= wr_data;
            if (armed && commit)
                act <= pend;
            if (arm_set)
                armed <= 1'b1;
            else if (commit)
                armed <= 1'b0;
        end
    end

    // R4: an unarmed register keeps its active value
    a_r4_hold_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> act == $past(act));
    // R3: an armed register takes its pending value at the strobe
    a_r3_commit_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && commit) |=> act == $past(pend));
    // R9: an armed register stays armed until the strobe
    a_r9_arm_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !commit) |=> armed);
endmodule

// File: rtl/plane_arm_fsm.sv
module plane_arm_fsm
    import plane_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_set,
    input  logic commit,
    output logic arm_busy
);
    arm_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: if (any_set) state_d = ST_ARMED;
            ST_ARMED: if (commit && !any_set) state_d = ST_QUIET;
            default:  state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_ARMED: arm_busy = 1'b1;
            default:  arm_busy = 1'b0;
        endcase
    end

    // R10: a strobe with no arming write returns the status to idle
    a_r10_clears_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !any_set) |=> !arm_busy);
endmodule

// File: rtl/plane_shadow_regs.sv
module plane_shadow_regs
    import plane_regs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int EN_BIT = 31
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    input  logic                          frame_tick,
    output logic [PR_NUM_REGS*DATA_W-1:0] act_flat,
    output logic                          plane_on,
    output logic                          arm_busy
);
    localparam int NREG = PR_NUM_REGS;

    logic [DATA_W-1:0] pend [NREG];
    logic [DATA_W-1:0] act  [NREG];
    logic [NREG-1:0]   armed;
    logic [NREG-1:0]   arm_set;
    logic [NREG-1:0]   hit;
    logic              surf_hit;

    assign surf_hit = wr_en && (wr_addr == ADDR_W'(IDX_SURF));
    assign plane_on = act[IDX_CTRL][EN_BIT];

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        localparam arm_rule_e RULE = rule_of(g);

        assign hit[g] = wr_en && (wr_addr == ADDR_W'(g));

        if (RULE == ARM_SELF) begin : g_self
            assign arm_set[g] = hit[g];
        end else if (RULE == ARM_BY_SURF) begin : g_surf
            assign arm_set[g] = surf_hit;
        end else begin : g_cond
            assign arm_set[g] = surf_hit | (hit[g] & ~plane_on);
        end

        plane_reg_slot #(.DATA_W(DATA_W)) slot_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (hit[g]),
            .wr_data (wr_data),
            .arm_set (arm_set[g]),
            .commit  (frame_tick),
            .pend    (pend[g]),
            .act     (act[g]),
            .armed   (armed[g])
        );

        assign act_flat[g*DATA_W +: DATA_W] = act[g];
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr < ADDR_W'(NREG))
            rd_data = pend[rd_addr];
    end

    plane_arm_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_set  (|arm_set),
        .commit   (frame_tick),
        .arm_busy (arm_busy)
    );

    // R10: the status state machine agrees with the per-register flags
    a_r10_status_match: assert property (@(posedge clk) disable iff (!rst_n)
        arm_busy == (|armed));
    // R5: a control write on a disabled plane sets the status flag
    a_r5_ctrl_self_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(IDX_CTRL) && !plane_on) |=> arm_busy);
    // R11: a write outside the map arms nothing
    a_r11_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= ADDR_W'(NREG) && !arm_busy && !frame_tick) |=> !arm_busy);
endmodule

// File: tb/plane_shadow_regs_tb_top.sv
module plane_shadow_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 12;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              wr_en = 0;
    logic [3:0]        wr_addr = 0;
    logic [31:0]       wr_data = 0;
    logic [3:0]        rd_addr = 0;
    logic [31:0]       rd_data;
    logic              frame_tick = 0;
    logic [NREG*32-1:0] act_flat;
    logic              plane_on;
    logic              arm_busy;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    plane_shadow_regs dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .frame_tick(frame_tick), .act_flat(act_flat),
        .plane_on(plane_on), .arm_busy(arm_busy)
    );

    function automatic logic [31:0] act(input int i);
        return act_flat[i*32 +: 32];
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic tick();
        frame_tick = 1;
        @(negedge clk);
        frame_tick = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < NREG; i++) begin
            chk("R1 active", act(i), 0);
            rd(4'(i), v);
            chk("R1 pending", v, 0);
        end
        chk("R1 plane_on", 32'(plane_on), 0);
        chk("R1 arm_busy", 32'(arm_busy), 0);
    endtask

    task automatic t_surface_group();
        logic [31:0] v;
        wr(2, 32'h100);
        wr(3, {16'd20, 16'd10});
        wr(5, 32'h3);
        rd(2, v);
        chk("R2 pending readback", v, 32'h100);
        chk("R2 active untouched", act(2), 0);
        chk("R10 busy low without surface", 32'(arm_busy), 0);
        tick();
        chk("R4 stride not copied", act(2), 0);
        chk("R4 position not copied", act(3), 0);
        wr(1, 32'h8000);
        chk("R10 busy after surface", 32'(arm_busy), 1);
        tick();
        chk("R3 surface copied", act(1), 32'h8000);
        chk("R3 stride copied", act(2), 32'h100);
        chk("R3 position copied", act(3), {16'd20, 16'd10});
        chk("R3 scale copied", act(5), 32'h3);
        chk("R10 busy cleared", 32'(arm_busy), 0);
    endtask

    task automatic t_ctrl_self();
        wr(0, 32'h8000_0001);
        chk("R10 busy after ctrl", 32'(arm_busy), 1);
        tick();
        chk("R5 ctrl active", act(0), 32'h8000_0001);
        chk("R5 plane_on", 32'(plane_on), 1);
    endtask

    task automatic t_ctrl_wait();
        wr(0, 32'h8000_0002);
        chk("R6 no arm while enabled", 32'(arm_busy), 0);
        tick();
        chk("R6 ctrl held", act(0), 32'h8000_0001);
        wr(1, 32'h9000);
        tick();
        chk("R6 ctrl after surface", act(0), 32'h8000_0002);
        chk("R3 surface update", act(1), 32'h9000);
    endtask

    task automatic t_offsets();
        for (int i = 6; i < 10; i++) wr(4'(i), 32'h60 + 32'(i));
        chk("R7 busy", 32'(arm_busy), 1);
        tick();
        for (int i = 6; i < 10; i++) chk("R7 offset copied", act(i), 32'h60 + 32'(i));
        chk("R7 surface unchanged", act(1), 32'h9000);
    endtask

    task automatic t_csc();
        wr(10, 32'hA0A0);
        wr(11, 32'hB0B0);
        tick();
        chk("R8 csc A", act(10), 32'hA0A0);
        chk("R8 csc B", act(11), 32'hB0B0);
    endtask

    task automatic t_rewrite();
        wr(7, 32'h7);
        wr(7, 32'h9);
        tick();
        chk("R9 latest self value", act(7), 32'h9);
        wr(1, 32'hA000);
        wr(2, 32'h200);
        chk("R9 still armed", 32'(arm_busy), 1);
        tick();
        chk("R9 rewrite after surface", act(2), 32'h200);
        chk("R10 idle", 32'(arm_busy), 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(14, 32'hDEAD);
        chk("R11 no arm", 32'(arm_busy), 0);
        rd(14, v);
        chk("R11 read zero", v, 0);
        rd(12, v);
        chk("R11 read zero 12", v, 0);
    endtask

    task automatic t_disable();
        wr(0, 32'h0);
        wr(5, 32'h0);
        wr(1, 32'h0);
        chk("R12 still on before tick", 32'(plane_on), 1);
        tick();
        chk("R12 plane off", 32'(plane_on), 0);
        chk("R12 scale cleared", act(5), 0);
        chk("R12 surface cleared", act(1), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_surface_group();
        t_ctrl_self();
        t_ctrl_wait();
        t_offsets();
        t_csc();
        t_rewrite();
        t_unmapped();
        t_disable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog got=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule